// File: doc/BRIEF.md
# Multi-Cycle Byte/Word Memory Port

This block connects a processor's address and data registers to a byte-addressable memory with 16-bit words, where every access takes a fixed number of clock cycles. The processor forms a request from an enable, a read/write select, a byte/word size select, an address and write data. It keeps the enable high until the port answers. The port counts the access latency and raises a single-cycle ready flag in the cycle the access completes. In that cycle read data can be loaded into the data register, and a write is committed to memory.

On the memory side the port presents a word address, two byte-lane enables, lane-aligned write data and a write strobe. It accepts the addressed word back. Word accesses ignore the low address bit. Byte accesses pick their lane from that bit. Byte stores copy the low byte of the write data onto both lanes. Byte loads sign-extend the selected lane to 16 bits. The request is captured in the first cycle of an access, so later changes to the inputs during that access have no effect. Dropping the enable before ready abandons the access and leaves memory untouched.

Top module: `mc_mem_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rdy` and `mem_we` are 0.
- R2: With `req_en` held high, `rdy` is 1 only in the LATENCY-th consecutive enabled cycle (the 5th by default) and is low in the cycles before it. It is a one-cycle pulse.
- R3: If `req_en` stays high after a ready cycle, a new access starts in the next cycle. The following `rdy` comes exactly LATENCY cycles after the previous one.
- R4: Driving `req_en` low before `rdy` aborts the access. `mem_we` is not asserted and the memory contents are unchanged. The next enabled cycle starts a fresh count.
- R5: A word access (`req_byte`=0) drives `mem_addr` = address bits [15:1] and `mem_be`=2'b11. Address bit 0 has no effect on the result.
- R6: A byte store drives `mem_be`=2'b01 when address bit 0 is 0 (bits [7:0]) and 2'b10 when it is 1 (bits [15:8]). `mem_wdata` carries `req_wdata[7:0]` on both lanes.
- R7: A byte load returns the lane chosen by address bit 0 (0: bits [7:0], 1: bits [15:8]) on `rd_data[7:0]`, with bit 7 of that lane copied into `rd_data[15:8]`.
- R8: A word load returns the full 16-bit memory word on `rd_data` in the ready cycle.
- R9: `mem_we` is 1 only in the ready cycle of a write access and never during a read.
- R10: The write flag, size, address and write data are captured in the first enabled cycle. Changing them later in the same access changes neither the memory side outputs nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_en | input | 1 | Access enable, held high until `rdy` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (low byte used for byte stores) |
| rdy | output | 1 | Access completes in this cycle |
| rd_data | output | 16 | Read result, valid when `rdy` is high on a read |
| mem_addr | output | 15 | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 2 | Memory byte-lane enables |
| mem_wdata | output | 16 | Lane-aligned write data |
| mem_rdata | input | 16 | Addressed memory word |

## Verification
The assertions check on every cycle that ready is a single pulse and arrives only after exactly LATENCY enabled cycles. They also check that a low enable suppresses both ready and the write strobe, that the strobe occurs only with ready, that the memory address and lane enables stay constant through an access, and that byte loads come back sign-extended. Only the bench's scenarios can show that a value was stored in the right lane and reads back intact. The same holds for an aborted write leaving memory unchanged, back-to-back accesses spacing correctly, and a mid-access change of address or data being ignored.

// File: rtl/mc_mem_pkg.sv
package mc_mem_pkg;
    localparam int MP_ADDR_W  = 16;
    localparam int MP_DATA_W  = 16;
    localparam int MP_BYTE_W  = 8;
    localparam int MP_LANES   = MP_DATA_W / MP_BYTE_W;
    localparam int MP_WADDR_W = MP_ADDR_W - 1;

    typedef struct packed {
        logic                 wr;
        logic                 bsel;
        logic [MP_ADDR_W-1:0] addr;
        logic [MP_DATA_W-1:0] wdata;
    } mp_req_t;
endpackage

// File: rtl/mc_lat_timer.sv
module mc_lat_timer #(
    parameter int LATENCY = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic first_o,
    output logic done_o
);
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LATENCY - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign first_o = (st_q.cnt == '0);
    assign done_o  = en_i && (st_q.cnt == LAST);
endmodule

// File: rtl/mc_lane_map.sv
module mc_lane_map
    import mc_mem_pkg::*;
(
    input  mp_req_t                 req_i,
    output logic [MP_WADDR_W-1:0]   waddr_o,
    output logic [MP_LANES-1:0]     be_o,
    output logic [MP_DATA_W-1:0]    wdata_o
);
    always_comb begin
        waddr_o = req_i.addr[MP_ADDR_W-1:1];
        if (req_i.bsel) begin
            be_o    = req_i.addr[0] ? 2'b10 : 2'b01;
            wdata_o = {req_i.wdata[MP_BYTE_W-1:0], req_i.wdata[MP_BYTE_W-1:0]};
        end else begin
            be_o    = '1;
            wdata_o = req_i.wdata;
        end
    end
endmodule

// File: rtl/mc_rd_extract.sv
module mc_rd_extract
    import mc_mem_pkg::*;
#(
    parameter bit SIGN_EXT = 1'b1
) (
    input  logic                  bsel_i,
    input  logic                  lane_i,
    input  logic [MP_DATA_W-1:0]  word_i,
    output logic [MP_DATA_W-1:0]  data_o
);
    logic [MP_BYTE_W-1:0] lane_byte;
    logic [MP_BYTE_W-1:0] fill;

    assign lane_byte = lane_i ? word_i[MP_DATA_W-1:MP_BYTE_W] : word_i[MP_BYTE_W-1:0];

    generate
        if (SIGN_EXT) begin : g_sext
            assign fill = {MP_BYTE_W{lane_byte[MP_BYTE_W-1]}};
        end else begin : g_zext
            assign fill = '0;
        end
    endgenerate

    assign data_o = bsel_i ? {fill, lane_byte} : word_i;
endmodule

// File: rtl/mc_mem_port.sv
module mc_mem_port
    import mc_mem_pkg::*;
#(
    parameter int LATENCY = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_en,
    input  logic                   req_wr,
    input  logic                   req_byte,
    input  logic [MP_ADDR_W-1:0]   req_addr,
    input  logic [MP_DATA_W-1:0]   req_wdata,
    output logic                   rdy,
    output logic [MP_DATA_W-1:0]   rd_data,
    output logic [MP_WADDR_W-1:0]  mem_addr,
    output logic                   mem_we,
    output logic [MP_LANES-1:0]    mem_be,
    output logic [MP_DATA_W-1:0]   mem_wdata,
    input  logic [MP_DATA_W-1:0]   mem_rdata
);
    mp_req_t in_req, cap_d, cap_q, act_req;
    logic    first, done;

    assign in_req = '{wr: req_wr, bsel: req_byte, addr: req_addr, wdata: req_wdata};

    mc_lat_timer #(.LATENCY(LATENCY)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (req_en),
        .first_o (first),
        .done_o  (done)
    );

    always_comb begin
        cap_d = cap_q;
        if (req_en && first) begin
            cap_d = in_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign act_req = first ? in_req : cap_q;

    mc_lane_map u_map (
        .req_i   (act_req),
        .waddr_o (mem_addr),
        .be_o    (mem_be),
        .wdata_o (mem_wdata)
    );

    mc_rd_extract #(.SIGN_EXT(1'b1)) u_rdx (
        .bsel_i (act_req.bsel),
        .lane_i (act_req.addr[0]),
        .word_i (mem_rdata),
        .data_o (rd_data)
    );

    assign rdy    = done;
    assign mem_we = done && act_req.wr;
endmodule

// File: rtl/mc_mem_port_chk.sv
module mc_mem_port_chk
    import mc_mem_pkg::*;
#(
    parameter int LATENCY = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_en,
    input logic                  rdy,
    input logic [MP_DATA_W-1:0]  rd_data,
    input logic [MP_WADDR_W-1:0] mem_addr,
    input logic                  mem_we,
    input logic [MP_LANES-1:0]   mem_be
);
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !req_en || rdy) begin
            run_q <= '0;
        end else if (run_q != 32'hFFFF_FFFF) begin
            run_q <= run_q + 1;
        end
    end

    // R2
    rdy_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> run_q == 32'(LATENCY - 1));

    // R2
    rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LATENCY > 1 && rdy) |=> !rdy);

    // R4
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_en |-> (!rdy && !mem_we));

    // R9
    we_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (rdy && mem_be != '0));

    // R10
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && run_q != 0) |-> ($stable(mem_addr) && $stable(mem_be)));

    // R7
    byte_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !mem_we && $countones(mem_be) == 1)
            |-> rd_data[MP_DATA_W-1:MP_BYTE_W] == {MP_BYTE_W{rd_data[MP_BYTE_W-1]}});
endmodule

bind mc_mem_port mc_mem_port_chk #(.LATENCY(LATENCY)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_en   (req_en),
    .rdy      (rdy),
    .rd_data  (rd_data),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_be   (mem_be)
);

// File: tb/sim_mc_mem_port.sv
`timescale 1ns/1ps
module sim_mc_mem_port;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_en = 1'b0, req_wr = 1'b0, req_byte = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        rdy, mem_we;
    logic [15:0] rd_data, mem_wdata, mem_rdata;
    logic [14:0] mem_addr;
    logic [1:0]  mem_be;

    int tests = 0, fails = 0;
    bit finished = 0;

    logic [15:0] mem [256];
    logic [15:0] shadow [256];

    always #2 clk = ~clk;

    mc_mem_port #(.LATENCY(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr),
        .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
        .rdy(rdy), .rd_data(rd_data), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_be[0]) mem[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    int          run = 0;
    logic        l_wr, l_byte;
    logic [15:0] l_addr, l_wdata;

    function automatic logic [15:0] ref_read(input logic [15:0] a, input logic b);
        logic [15:0] w;
        logic [7:0]  lane;
        w = shadow[a[8:1]];
        lane = a[0] ? w[15:8] : w[7:0];
        return b ? {{8{lane[7]}}, lane} : w;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            logic        a_wr, a_byte, e_rdy, e_we;
            logic [15:0] a_addr, a_wd;
            logic [1:0]  e_be;
            logic [15:0] e_wd;
            a_wr   = (run == 0) ? req_wr    : l_wr;
            a_byte = (run == 0) ? req_byte  : l_byte;
            a_addr = (run == 0) ? req_addr  : l_addr;
            a_wd   = (run == 0) ? req_wdata : l_wdata;
            e_rdy  = req_en && run == LAT - 1;
            e_we   = e_rdy && a_wr;
            e_be   = a_byte ? (a_addr[0] ? 2'b10 : 2'b01) : 2'b11;
            e_wd   = a_byte ? {a_wd[7:0], a_wd[7:0]} : a_wd;
            chk(rdy === e_rdy, "R2/R3/R4 rdy", 32'(rdy), 32'(e_rdy));
            chk(mem_we === e_we, "R9 mem_we", 32'(mem_we), 32'(e_we));
            if (req_en) begin
                chk(mem_addr === a_addr[15:1], "R5/R10 mem_addr", 32'(mem_addr), 32'(a_addr[15:1]));
                chk(mem_be === e_be, "R5/R6 mem_be", 32'(mem_be), 32'(e_be));
            end
            if (e_we) chk(mem_wdata === e_wd, "R6 mem_wdata", 32'(mem_wdata), 32'(e_wd));
            if (e_rdy && !a_wr)
                chk(rd_data === ref_read(a_addr, a_byte), "R7/R8 rd_data",
                    32'(rd_data), 32'(ref_read(a_addr, a_byte)));
        end
    end

    always @(posedge clk) begin
        if (!rst_n || !req_en) begin
            run = 0;
        end else begin
            if (run == 0) begin
                l_wr = req_wr; l_byte = req_byte; l_addr = req_addr; l_wdata = req_wdata;
            end
            if (run == LAT - 1) begin
                if (l_wr) begin
                    if (!l_byte) shadow[l_addr[8:1]] = l_wdata;
                    else if (l_addr[0]) shadow[l_addr[8:1]][15:8] = l_wdata[7:0];
                    else shadow[l_addr[8:1]][7:0] = l_wdata[7:0];
                end
                run = 0;
            end else begin
                run = run + 1;
            end
        end
    end

    task automatic access(input logic wr, input logic b, input logic [15:0] a,
                          input logic [15:0] wd, output logic [15:0] rd);
        @(posedge clk); #1;
        req_en = 1; req_wr = wr; req_byte = b; req_addr = a; req_wdata = wd;
        forever begin
            @(negedge clk);
            if (rdy) begin rd = rd_data; break; end
        end
        @(posedge clk); #1;
        req_en = 0;
    endtask

    initial begin
        logic [15:0] r;
        int gap;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'(i * 16'h0137 + 16'h5A3C);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        chk(rdy === 1'b0, "R1 rdy in reset", 32'(rdy), 0);
        chk(mem_we === 1'b0, "R1 mem_we in reset", 32'(mem_we), 0);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk(rdy === 1'b0 && mem_we === 1'b0, "R1 after reset", 32'({rdy, mem_we}), 0);

        // R5 R8: word write then reads with bit 0 clear and set
        access(1, 0, 16'h0010, 16'hBEEF, r);
        access(0, 0, 16'h0010, 16'h0, r);
        chk(r === 16'hBEEF, "R8 word read", 32'(r), 32'hBEEF);
        access(0, 0, 16'h0011, 16'h0, r);
        chk(r === 16'hBEEF, "R5 bit0 ignored", 32'(r), 32'hBEEF);

        // R6: byte stores in both lanes
        access(1, 1, 16'h0020, 16'h33A5, r);
        access(1, 1, 16'h0021, 16'h447E, r);
        access(0, 0, 16'h0020, 16'h0, r);
        chk(r === 16'h7EA5, "R6 byte lanes", 32'(r), 32'h7EA5);

        // R7: sign extension of each lane
        access(0, 1, 16'h0020, 16'h0, r);
        chk(r === 16'hFFA5, "R7 low lane negative", 32'(r), 32'hFFA5);
        access(0, 1, 16'h0021, 16'h0, r);
        chk(r === 16'h007E, "R7 high lane positive", 32'(r), 32'h007E);

        // R3: back-to-back accesses with enable held
        @(posedge clk); #1;
        req_en = 1; req_wr = 0; req_byte = 0; req_addr = 16'h0040;
        do @(negedge clk); while (!rdy);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!rdy);
        chk(gap == LAT, "R3 back-to-back spacing", 32'(gap), LAT);
        @(posedge clk); #1 req_en = 0;

        // R4: aborted write leaves memory unchanged
        @(posedge clk); #1;
        req_en = 1; req_wr = 1; req_byte = 0; req_addr = 16'h0050; req_wdata = 16'h1234;
        repeat (3) @(posedge clk);
        #1 req_en = 0;
        access(0, 0, 16'h0050, 16'h0, r);
        chk(r === shadow[8'h28], "R4 abort keeps memory", 32'(r), 32'(shadow[8'h28]));
        chk(r !== 16'h1234, "R4 abort no write", 32'(r), 32'(shadow[8'h28]));

        // R10: inputs changed mid-access are ignored
        @(posedge clk); #1;
        req_en = 1; req_wr = 1; req_byte = 0; req_addr = 16'h0060; req_wdata = 16'hCAFE;
        @(posedge clk); #1;
        req_addr = 16'h0070; req_wdata = 16'h0BAD; req_wr = 0; req_byte = 1;
        do @(negedge clk); while (!rdy);
        @(posedge clk); #1 req_en = 0;
        access(0, 0, 16'h0060, 16'h0, r);
        chk(r === 16'hCAFE, "R10 captured write", 32'(r), 32'hCAFE);
        access(0, 0, 16'h0070, 16'h0, r);
        chk(r === shadow[8'h38], "R10 other address untouched", 32'(r), 32'(shadow[8'h38]));

        repeat (3) @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule